// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This unit watches the hot-plug-detect wire of a display connector and turns it into a clean connection level plus interrupt events. The raw wire is synchronized into the local clock domain. It then passes through a programmable glitch filter: a prescaler divides the clock down to a filter tick, and the filtered level only moves after the synchronized input has disagreed with it for a programmed number of consecutive ticks.

Every change of the filtered level raises a sticky event bit, one for rising and one for falling. A third sticky bit records the interrupt input of an attached controller core. Software clears the sticky bits by writing ones to a dedicated clear word. An enable word selects which sticky bits drive the single level interrupt output, with a 1 meaning enabled.

Access is through a plain internal register port. It has a word address, write data and a write strobe, and the read data is a combinational decode of the address.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset, the filtered level, the sticky bits, the enable word and both filter fields are 0, and `irq_o` is 0.
- R2: The filter tick fires every PRE+1 clocks, where PRE is the prescale field. The raw input reaches the filter through two flops. The filtered level takes the synchronized value on the tick on which it has differed for THR+1 consecutive ticks, where THR is the threshold field. With both fields 0, a raw change is visible at the level word after three clock edges.
- R3: If the synchronized input returns to the filtered level before the threshold is met, the tick count restarts. The level then does not move and no event is raised.
- R4: Reading word address 0 returns the filtered level in bit 0, with the other bits 0.
- R5: Word address 1 returns the sticky bits: bit 1 is set by a rising filtered edge and bit 2 by a falling one. The bits hold until cleared and are set in the same edge on which the level changes.
- R6: Bit 0 of the sticky word is set on every clock on which `core_irq_i` is high, and it holds after the input drops.
- R7: Writing word address 2 clears each sticky bit whose data bit is 1 and leaves the bits written with 0 unchanged. Address 2 reads as 0.
- R8: When a clear and a set of the same sticky bit fall in the same cycle, the bit ends up set.
- R9: Word address 3 holds a read/write enable with one bit per sticky bit, in the same positions. `irq_o` is high exactly when some sticky bit and its enable bit are both 1.
- R10: Word address 4 holds the prescale field in bits 15:12 and the threshold field in bits 7:0. Bits 11:8 read as 0.
- R11: Word addresses 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpd_raw_i | input | 1 | Asynchronous hot-plug wire from the connector |
| core_irq_i | input | 1 | Interrupt request of the attached core |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The bench drives a short bounce that stays under the filter window. A filter that counts total ticks instead of consecutive ones would move the level and raise a false fall event. It also measures the exact edge on which an unfiltered change appears, which catches a missing or extra synchronizer stage.

A clear is issued in the same cycle as a core request, so a design that lets the clear win would drop the bit. A long-window run with the programmed filter value brackets the tick count from both sides, which exposes an off-by-one in the prescaler or the threshold compare. Random toggling and random clears are then compared clock by clock against the reference model.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_SRC = 3;

  // sticky bit positions
  localparam int SRC_CORE = 0;
  localparam int SRC_RISE = 1;
  localparam int SRC_FALL = 2;

  // word addresses
  localparam logic [ADDR_W-1:0] A_LEVEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_FILT  = 3'd4;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // a set in the same cycle beats a clear
  function automatic src_vec_t sticky_next(src_vec_t cur, src_vec_t clr, src_vec_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_enabled(src_vec_t stat, src_vec_t en);
    return |(stat & en);
  endfunction
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hpd_glitch_filter.sv
module hpd_glitch_filter #(
  parameter int PRE_W = 4,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             level_o,
  output logic             tick_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PRE_W-1:0] pre_cnt_q;
  logic [THR_W-1:0] run_cnt_q;
  logic             level_q;
  logic             differs;
  logic             accept;

  assign tick_o  = (pre_cnt_q >= pre_i);
  assign differs = (sync_i != level_q);
  assign accept  = tick_o && differs && (run_cnt_q >= thr_i);
  assign rise_o  = accept &&  sync_i;
  assign fall_o  = accept && !sync_i;
  assign level_o = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      run_cnt_q <= '0;
      level_q   <= 1'b0;
    end else begin
      pre_cnt_q <= tick_o ? '0 : pre_cnt_q + PRE_W'(1);
      if (!differs) begin
        run_cnt_q <= '0;
      end else if (tick_o) begin
        if (accept) begin
          level_q   <= sync_i;
          run_cnt_q <= '0;
        end else begin
          run_cnt_q <= run_cnt_q + THR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hpd_event_regs.sv
module hpd_event_regs
  import hpd_irq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_W   = 4,
  parameter int THR_W   = 8,
  parameter int PRE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              level_i,
  input  src_vec_t          set_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [THR_W-1:0]  thr_o,
  output src_vec_t          stat_o,
  output src_vec_t          en_o,
  output src_vec_t          clr_o,
  output logic              irq_o
);
  src_vec_t         stat_q;
  src_vec_t         en_q;
  logic [PRE_W-1:0] pre_q;
  logic [THR_W-1:0] thr_q;
  logic             unused_gap;

  assign unused_gap = ^wdata_i[PRE_LSB-1:THR_W];

  assign clr_o = (wr_i && addr_i == A_CLR) ? wdata_i[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      pre_q  <= '0;
      thr_q  <= '0;
    end else begin
      stat_q <= sticky_next(stat_q, clr_o, set_i);
      if (wr_i && addr_i == A_EN) en_q <= wdata_i[NUM_SRC-1:0];
      if (wr_i && addr_i == A_FILT) begin
        pre_q <= wdata_i[PRE_LSB +: PRE_W];
        thr_q <= wdata_i[THR_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LEVEL: rdata_o[0] = level_i;
      A_STAT:  rdata_o[NUM_SRC-1:0] = stat_q;
      A_EN:    rdata_o[NUM_SRC-1:0] = en_q;
      A_FILT: begin
        rdata_o[PRE_LSB +: PRE_W] = pre_q;
        rdata_o[THR_W-1:0]        = thr_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pre_o  = pre_q;
  assign thr_o  = thr_q;
  assign irq_o  = any_enabled(stat_q, en_q);
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PRE_W       = 4,
  parameter int THR_W       = 8,
  parameter int PRE_LSB     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpd_raw_i,
  input  logic              core_irq_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic             sync_w;
  logic             level_w;
  logic             tick_w;
  logic             rise_w;
  logic             fall_w;
  logic [PRE_W-1:0] pre_w;
  logic [THR_W-1:0] thr_w;
  src_vec_t         set_w;
  src_vec_t         stat_w;
  src_vec_t         en_w;
  src_vec_t         clr_w;

  hpd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hpd_raw_i),
    .q_o   (sync_w)
  );

  hpd_glitch_filter #(.PRE_W(PRE_W), .THR_W(THR_W)) i_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_w),
    .pre_i   (pre_w),
    .thr_i   (thr_w),
    .level_o (level_w),
    .tick_o  (tick_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  always_comb begin
    set_w           = '0;
    set_w[SRC_CORE] = core_irq_i;
    set_w[SRC_RISE] = rise_w;
    set_w[SRC_FALL] = fall_w;
  end

  hpd_event_regs #(
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W),
    .THR_W  (THR_W),
    .PRE_LSB(PRE_LSB)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .level_i (level_w),
    .set_i   (set_w),
    .pre_o   (pre_w),
    .thr_o   (thr_w),
    .stat_o  (stat_w),
    .en_o    (en_w),
    .clr_o   (clr_w),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/hpd_irq_checker.sv
module hpd_irq_checker
  import hpd_irq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     tick,
  input logic     sync,
  input logic     level,
  input logic     rise,
  input logic     fall,
  input logic     core,
  input src_vec_t stat,
  input src_vec_t en,
  input src_vec_t clr,
  input logic     irq
);
  // R2
  level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> $past(tick));

  // R2
  level_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> (level == $past(sync)));

  // R5
  rise_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> stat[SRC_RISE]);

  // R5
  fall_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> stat[SRC_FALL]);

  // R5
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));

  // R7
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[SRC_RISE] && !rise) |=> !stat[SRC_RISE]);

  // R8
  core_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[SRC_CORE] && core) |=> stat[SRC_CORE]);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind hpd_irq_unit hpd_irq_checker i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick_w),
  .sync  (sync_w),
  .level (level_w),
  .rise  (rise_w),
  .fall  (fall_w),
  .core  (core_irq_i),
  .stat  (stat_w),
  .en    (en_w),
  .clr   (clr_w),
  .irq   (irq_o)
);

// File: tb/test_hpd_irq_unit.sv
`timescale 1ns/1ps
module test_hpd_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hpd_raw = 1'b0;
  logic        core_irq = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  hpd_irq_unit i_hpd_irq_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .hpd_raw_i   (hpd_raw),
    .core_irq_i  (core_irq),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  // ---------------- behavioural reference model ----------------
  bit sync_q[$];
  int m_pre, m_cnt, m_cfg_pre, m_cfg_thr;
  bit m_level;
  bit [2:0] m_stat, m_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      sync_q = '{1'b0, 1'b0};
      m_pre = 0; m_cnt = 0; m_cfg_pre = 0; m_cfg_thr = 0;
      m_level = 0; m_stat = 0; m_en = 0;
    end else begin
      bit s, tk, up, dn;
      bit [2:0] clr, set;
      s = sync_q.pop_front();
      sync_q.push_back(hpd_raw);
      tk = (m_pre >= m_cfg_pre);
      m_pre = tk ? 0 : m_pre + 1;
      up = 0; dn = 0;
      if (s == m_level) m_cnt = 0;
      else if (tk) begin
        if (m_cnt >= m_cfg_thr) begin
          m_level = s; up = s; dn = !s; m_cnt = 0;
        end else m_cnt = m_cnt + 1;
      end
      clr = (reg_wr && reg_addr == 3'd2) ? reg_wdata[2:0] : 3'b000;
      set = {dn, up, core_irq};
      m_stat = (m_stat & ~clr) | set;
      if (reg_wr && reg_addr == 3'd3) m_en = reg_wdata[2:0];
      if (reg_wr && reg_addr == 3'd4) begin
        m_cfg_pre = reg_wdata[15:12];
        m_cfg_thr = reg_wdata[7:0];
      end
    end
  end

  function automatic logic [15:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return {15'h0, m_level};
      3'd1: return {13'h0, m_stat};
      3'd3: return {13'h0, m_en};
      3'd4: return 16'((m_cfg_pre << 12) | m_cfg_thr);
      default: return 16'h0;
    endcase
  endfunction

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #4;
    if (rst_n && !done) begin
      vectors++;
      if (reg_rdata !== model_read(reg_addr) || irq !== |(m_stat & m_en)) begin
        fails++;
        $display("FAIL %s cycle addr=%0d rdata=%h exp=%h irq=%b exp=%b", cur_tag,
                 reg_addr, reg_rdata, model_read(reg_addr), irq, |(m_stat & m_en));
      end
    end
  end

  // ---------------- helpers (start and end at a falling edge) ----------------
  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_rd(logic [2:0] a, logic [15:0] exp, string tag);
    reg_addr = a;
    #2;
    vectors++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr=%0d got=%h exp=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(logic exp, string tag);
    #1;
    vectors++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq got=%b exp=%b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(4);
    rst_n = 1'b1;
    // R1 reset state
    cur_tag = "R1";
    for (int a = 0; a < 5; a++) chk_rd(3'(a), 16'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2 exact latency with zero filter fields
    cur_tag = "R2";
    @(negedge clk);
    hpd_raw = 1'b1;
    cycles(2);
    chk_rd(3'd0, 16'h0, "R2");
    cycles(1);
    chk_rd(3'd0, 16'h1, "R2/R4");
    chk_rd(3'd1, 16'h2, "R5");
    chk_irq(1'b0, "R9");

    // R9 enable rise
    cur_tag = "R9";
    wr_reg(3'd3, 16'h2);
    chk_irq(1'b1, "R9");

    // R7 write-one-to-clear
    cur_tag = "R7";
    wr_reg(3'd2, 16'h0);
    chk_rd(3'd1, 16'h2, "R7");
    wr_reg(3'd2, 16'h2);
    chk_rd(3'd1, 16'h0, "R7");
    chk_irq(1'b0, "R7");
    chk_rd(3'd2, 16'h0, "R7");

    // R10 filter fields
    cur_tag = "R10";
    wr_reg(3'd4, 16'h1003);
    chk_rd(3'd4, 16'h1003, "R10");

    // R3 short bounce
    cur_tag = "R3";
    hpd_raw = 1'b0;
    cycles(3);
    hpd_raw = 1'b1;
    cycles(12);
    chk_rd(3'd0, 16'h1, "R3");
    chk_rd(3'd1, 16'h0, "R3");

    // R5 real fall
    cur_tag = "R5";
    hpd_raw = 1'b0;
    cycles(20);
    chk_rd(3'd0, 16'h0, "R5");
    chk_rd(3'd1, 16'h4, "R5");
    chk_irq(1'b0, "R9");
    wr_reg(3'd3, 16'h7);
    chk_irq(1'b1, "R9");

    // R6 core pulse is sticky
    cur_tag = "R6";
    core_irq = 1'b1;
    cycles(1);
    core_irq = 1'b0;
    cycles(2);
    chk_rd(3'd1, 16'h5, "R6");
    wr_reg(3'd2, 16'h5);
    chk_rd(3'd1, 16'h0, "R7");

    // R8 set wins over clear
    cur_tag = "R8";
    core_irq = 1'b1;
    wr_reg(3'd2, 16'h1);
    core_irq = 1'b0;
    cycles(1);
    chk_rd(3'd1, 16'h1, "R8");
    wr_reg(3'd2, 16'h1);
    chk_rd(3'd1, 16'h0, "R8");

    // R10 reserved bits, long window
    cur_tag = "R10";
    wr_reg(3'd4, 16'hFFFF);
    chk_rd(3'd4, 16'hF0FF, "R10");
    wr_reg(3'd4, 16'hA0A0);
    chk_rd(3'd4, 16'hA0A0, "R10");
    cur_tag = "R2";
    hpd_raw = 1'b1;
    cycles(1700);
    chk_rd(3'd0, 16'h0, "R2");
    cycles(100);
    chk_rd(3'd0, 16'h1, "R2");
    chk_rd(3'd1, 16'h2, "R5");

    // R11 unused addresses
    cur_tag = "R11";
    for (int a = 5; a < 8; a++) begin
      wr_reg(3'(a), 16'hFFFF);
      chk_rd(3'(a), 16'h0, "R11");
    end
    chk_rd(3'd4, 16'hA0A0, "R11");
    chk_rd(3'd3, 16'h7, "R11");
    wr_reg(3'd2, 16'h7);

    // random traffic against the model
    cur_tag = "R2/R5/R7";
    wr_reg(3'd4, 16'h0001);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) hpd_raw = ~hpd_raw;
      core_irq = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) begin
        wr_reg(3'd2, 16'($urandom_range(0, 7)));
      end else begin
        reg_addr = 3'($urandom_range(0, 4));
        @(negedge clk);
      end
    end
    core_irq = 1'b0;
    cycles(2);
    finish_run();
  end
endmodule